// File: doc/BRIEF.md
# Mixed-Radix Twiddle Address Generator

This block supplies the coefficient-table address for every operand of every butterfly in an in-place, memory-based FFT whose length is N = R1^S1 × R2^S2. The coefficient table holds N entries. Entry i is exp(-j2πi/N), so a table address is simply a twiddle exponent. The block runs beside the operand address logic. Both are fed from one shared mixed-radix counter, and no second counter or modulo unit is needed.

Each cycle the block takes the stage number and the counter digits C(S-1)…C0. Digit C0 is the operand index inside the current butterfly. The upper digits supply the frequency digits that are already resolved, in digit-reversed order, and these give a per-butterfly base exponent β. The address is C0 × β. The result leaves through a LAT-deep register pipe, so it reaches the datapath on the same cycle as the matching operand address. A flag marks any request whose exponent would fall outside the table.

Top module: `mrtw_twiddle_agen`

## Requirements
- R1: In stage 1, every accepted request yields address 0.
- R2: In any stage from 1 to S, a request whose operand index C0 is 0 yields address 0.
- R3: For stage m, let k_i = C(S-1-i). Then β = (Σ over i = 0 … m-2 of F_i·k_i) × T(S-m) and the address is C0 × β. F_i is the product of the radices of frequency digits below i; the low S2 frequency digits have radix R2 and the rest have radix R1. T_j is the product of the radices of time digits below j; the low S1 time digits have radix R1 and the rest have radix R2. With the defaults (R1=3, R2=2, S1=1, S2=2), F = 1, 2, 4 and T = 1, 3, 6.
- R4: With the defaults, in stage 2 the counter digit radices are C2:2, C1:3, C0:2. Counting 0 to 11, the 12 addresses are 0,0,0,0,0,0,0,3,0,3,0,3.
- R5: With the defaults, in stage 3 the counter digit radices are C2:2, C1:2, C0:3. Counting 0 to 11, the 12 addresses are 0,0,0,0,2,4,0,1,2,0,3,6.
- R6: Every request produces exactly one result, with tw_valid high exactly LAT cycles (default 2) after the cycle in which in_valid was sampled high. No result appears without a request.
- R7: If C0 × β ≥ N, tw_err is 1 and the address is 0. Otherwise tw_err is 0 and the address is below N.
- R8: A stage value of 0 or above S gives tw_err = 1 and address 0.
- R9: On the cycle after rst is sampled high, tw_valid, tw_addr and tw_err are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe |
| in_stage | input | SW = clog2(S+1) | Stage number, 1 to S |
| in_digits | input | S×DW | Counter digits; C_j sits at bits [j·DW +: DW], C0 is the operand index |
| tw_valid | output | 1 | Result strobe, LAT cycles after the request |
| tw_addr | output | AW = clog2(N) | Twiddle table address |
| tw_err | output | 1 | Exponent out of range or stage illegal |

## Verification
The bench sweeps complete stage-1, stage-2 and stage-3 counts of the 12-point case. A wrong digit-reversal order would move the nonzero exponents to the wrong counts, and a missing stage weight would give 1 in place of 3 in stage 2. Extra vectors with C0 = 0 catch a design that lets β leak into operand 0. Vectors with digits out of range push the product to exactly N and above it, to show where the error flag switches. A stage-0 request checks that an illegal stage is flagged and not decoded as stage 1. Idle gaps between requests, and back-to-back requests, expose a pipe whose depth differs from LAT or that emits results nobody asked for.

// File: rtl/mrtw_pkg.sv
package mrtw_pkg;

  // radix of time digit j: the low s1 digits use r1, the rest r2
  function automatic int time_radix(int j, int r1, int r2, int s1);
    return (j < s1) ? r1 : r2;
  endfunction

  // radix of frequency digit i: the low s2 digits use r2, the rest r1
  function automatic int freq_radix(int i, int r1, int r2, int s2);
    return (i < s2) ? r2 : r1;
  endfunction

  // positional weight of time digit j
  function automatic int time_weight(int j, int r1, int r2, int s1);
    int w;
    w = 1;
    for (int t = 0; t < j; t++) w = w * time_radix(t, r1, r2, s1);
    return w;
  endfunction

  // positional weight of frequency digit i
  function automatic int freq_weight(int i, int r1, int r2, int s2);
    int w;
    w = 1;
    for (int t = 0; t < i; t++) w = w * freq_radix(t, r1, r2, s2);
    return w;
  endfunction

endpackage

// File: rtl/mrtw_beta.sv
// Base exponent from the upper counter digits, read in reversed order.
module mrtw_beta #(
  parameter int R1 = 3,
  parameter int R2 = 2,
  parameter int S1 = 1,
  parameter int S2 = 2,
  parameter int DW = 2,
  parameter int SW = 2,
  parameter int BW = 7,
  localparam int S = S1 + S2
) (
  input  logic [SW-1:0]       stage,
  input  logic [(S-1)*DW-1:0] hi_digits,   // C(S-1)..C1, C1 at the bottom
  output logic [BW-1:0]       beta,
  output logic                stage_ok
);

  logic [BW-1:0] term [S-1];
  logic [BW-1:0] stw  [S];
  logic [BW-1:0] bsum;
  logic [BW-1:0] sel_w;

  // frequency digit k_i is counter digit C(S-1-i); it counts from stage i+2 on
  for (genvar i = 0; i < S - 1; i++) begin : g_term
    localparam int FW = mrtw_pkg::freq_weight(i, R1, R2, S2);
    logic [BW-1:0] dig;
    assign dig     = BW'(hi_digits[(S-2-i)*DW +: DW]);
    assign term[i] = (stage >= SW'(i + 2)) ? dig * BW'(FW) : '0;
  end

  // stage m scales by the weight of time digit S-m
  for (genvar m = 1; m <= S; m++) begin : g_stw
    assign stw[m-1] = BW'(mrtw_pkg::time_weight(S - m, R1, R2, S1));
  end

  always_comb begin
    bsum = '0;
    for (int i = 0; i < S - 1; i++) bsum = bsum + term[i];
  end

  always_comb begin
    sel_w    = '0;
    stage_ok = 1'b0;
    for (int m = 1; m <= S; m++) begin
      if (stage == SW'(m)) begin
        sel_w    = stw[m-1];
        stage_ok = 1'b1;
      end
    end
  end

  assign beta = bsum * sel_w;

endmodule

// File: rtl/mrtw_scale.sv
// Operand index times base exponent, with a table-range check.
module mrtw_scale #(
  parameter int DW = 2,
  parameter int BW = 7,
  parameter int AW = 4,
  parameter int N  = 12,
  localparam int PW = BW + DW
) (
  input  logic [DW-1:0] op_idx,
  input  logic [BW-1:0] beta,
  input  logic          stage_ok,
  output logic [AW-1:0] addr,
  output logic          err
);

  logic [PW-1:0] prod;
  logic          over;

  assign prod = PW'(op_idx) * PW'(beta);
  assign over = (prod >= PW'(N));
  assign err  = !stage_ok || over;
  assign addr = err ? '0 : AW'(prod);

endmodule

// File: rtl/mrtw_pipe.sv
// LAT-deep register pipe; the result leaves registered.
module mrtw_pipe #(
  parameter int W   = 5,
  parameter int LAT = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_v,
  input  logic [W-1:0] in_d,
  output logic         out_v,
  output logic [W-1:0] out_d
);

  logic         v_q [LAT];
  logic [W-1:0] d_q [LAT];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int g = 0; g < LAT; g++) begin
        v_q[g] <= 1'b0;
        d_q[g] <= '0;
      end
    end else begin
      v_q[0] <= in_v;
      d_q[0] <= in_d;
      for (int g = 1; g < LAT; g++) begin
        v_q[g] <= v_q[g-1];
        d_q[g] <= d_q[g-1];
      end
    end
  end

  assign out_v = v_q[LAT-1];
  assign out_d = d_q[LAT-1];

endmodule

// File: rtl/mrtw_twiddle_agen.sv
module mrtw_twiddle_agen #(
  parameter int R1  = 3,
  parameter int R2  = 2,
  parameter int S1  = 1,
  parameter int S2  = 2,
  parameter int LAT = 2,
  localparam int S  = S1 + S2,
  localparam int RMAX = (R1 > R2) ? R1 : R2,
  localparam int DW = $clog2(RMAX),
  localparam int SW = $clog2(S + 1),
  localparam int N  = mrtw_pkg::time_weight(S, R1, R2, S1),
  localparam int AW = $clog2(N),
  localparam int BW = AW + DW + 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [SW-1:0]   in_stage,
  input  logic [S*DW-1:0] in_digits,
  output logic            tw_valid,
  output logic [AW-1:0]   tw_addr,
  output logic            tw_err
);

  logic [BW-1:0] beta;
  logic          stage_ok;
  logic [AW-1:0] addr_c;
  logic          err_c;

  mrtw_beta #(
    .R1(R1), .R2(R2), .S1(S1), .S2(S2),
    .DW(DW), .SW(SW), .BW(BW)
  ) u_beta (
    .stage    (in_stage),
    .hi_digits(in_digits[S*DW-1:DW]),
    .beta     (beta),
    .stage_ok (stage_ok)
  );

  mrtw_scale #(
    .DW(DW), .BW(BW), .AW(AW), .N(N)
  ) u_scale (
    .op_idx  (in_digits[DW-1:0]),
    .beta    (beta),
    .stage_ok(stage_ok),
    .addr    (addr_c),
    .err     (err_c)
  );

  mrtw_pipe #(
    .W(AW + 1), .LAT(LAT)
  ) u_pipe (
    .clk  (clk),
    .rst  (rst),
    .in_v (in_valid),
    .in_d ({err_c, addr_c}),
    .out_v(tw_valid),
    .out_d({tw_err, tw_addr})
  );

endmodule

// File: rtl/mrtw_twiddle_agen_chk.sv
module mrtw_twiddle_agen_chk #(
  parameter int LAT = 2,
  parameter int SW  = 2,
  parameter int DW  = 2,
  parameter int AW  = 4,
  parameter int S   = 3,
  parameter int N   = 12
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic [SW-1:0] in_stage,
  input logic [DW-1:0] op_idx,
  input logic          tw_valid,
  input logic [AW-1:0] tw_addr,
  input logic          tw_err
);

  logic hv [LAT];
  logic h1 [LAT];
  logic hz [LAT];
  logic hb [LAT];

  logic legal_stage;
  assign legal_stage = (in_stage != '0) && (int'(in_stage) <= S);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int g = 0; g < LAT; g++) begin
        hv[g] <= 1'b0; h1[g] <= 1'b0; hz[g] <= 1'b0; hb[g] <= 1'b0;
      end
    end else begin
      hv[0] <= in_valid;
      h1[0] <= in_valid && (in_stage == SW'(1));
      hz[0] <= in_valid && legal_stage && (op_idx == '0);
      hb[0] <= in_valid && !legal_stage;
      for (int g = 1; g < LAT; g++) begin
        hv[g] <= hv[g-1]; h1[g] <= h1[g-1]; hz[g] <= hz[g-1]; hb[g] <= hb[g-1];
      end
    end
  end

  // R9
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!tw_valid && tw_addr == '0 && !tw_err));

  // R6
  latency_chk: assert property (@(posedge clk) disable iff (rst)
    tw_valid == hv[LAT-1]);

  // R1
  stage_one_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (tw_valid && h1[LAT-1]) |-> tw_addr == '0);

  // R2
  operand_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (tw_valid && hz[LAT-1]) |-> tw_addr == '0);

  // R8
  bad_stage_chk: assert property (@(posedge clk) disable iff (rst)
    (tw_valid && hb[LAT-1]) |-> tw_err);

  // R7
  err_addr_zero_chk: assert property (@(posedge clk) disable iff (rst)
    tw_err |-> tw_addr == '0);

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (tw_valid && !tw_err) |-> int'(tw_addr) < N);

endmodule

bind mrtw_twiddle_agen mrtw_twiddle_agen_chk #(
  .LAT(LAT), .SW(SW), .DW(DW), .AW(AW), .S(S), .N(N)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .in_valid(in_valid),
  .in_stage(in_stage),
  .op_idx  (in_digits[DW-1:0]),
  .tw_valid(tw_valid),
  .tw_addr (tw_addr),
  .tw_err  (tw_err)
);

// File: tb/tb_mrtw_twiddle_agen.sv
module tb_mrtw_twiddle_agen;

  localparam int CLK_PERIOD = 10;
  localparam int LAT = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [1:0] in_stage = '0;
  logic [5:0] in_digits = '0;
  logic       tw_valid;
  logic [3:0] tw_addr;
  logic       tw_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  mrtw_twiddle_agen #(.R1(3), .R2(2), .S1(1), .S2(2), .LAT(LAT)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_stage(in_stage),
    .in_digits(in_digits), .tw_valid(tw_valid), .tw_addr(tw_addr), .tw_err(tw_err)
  );

  typedef struct {
    int    a;
    bit    e;
    string r;
    int    t;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic void chk(bit ok, string rq, string what, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, expv);
    end
  endfunction

  // expected exponent from R3 with F = 1,2,4 and T = 1,3,6
  function automatic int model(int stg, int c2, int c1, int c0, output bit e);
    int fw[3] = '{1, 2, 4};
    int tw[3] = '{1, 3, 6};
    int k[3];
    int bp, p;
    k[0] = c2; k[1] = c1; k[2] = c0;
    if (stg < 1 || stg > 3) begin e = 1'b1; return 0; end
    bp = 0;
    for (int i = 0; i <= stg - 2; i++) bp += fw[i] * k[i];
    p = c0 * bp * tw[3 - stg];
    if (p >= 12) begin e = 1'b1; return 0; end
    e = 1'b0;
    return p;
  endfunction

  task automatic send(int stg, int c2, int c1, int c0, int ea, bit ee, string rq);
    exp_t it;
    @(negedge clk);
    in_valid  = 1'b1;
    in_stage  = 2'(stg);
    in_digits = {2'(c2), 2'(c1), 2'(c0)};
    it.a = ea; it.e = ee; it.r = rq; it.t = cyc;
    q.push_back(it);
  endtask

  task automatic idle(int n);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic send_model(int stg, int c2, int c1, int c0, string rq);
    bit e;
    int a;
    a = model(stg, c2, c1, c0, e);
    send(stg, c2, c1, c0, a, e, rq);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && tw_valid) begin
      if (q.size() == 0) begin
        chk(1'b0, "R6", "result without request", 1, 0);
      end else begin
        exp_t it;
        it = q.pop_front();
        chk(int'(tw_addr) == it.a, it.r, "tw_addr", int'(tw_addr), it.a);
        chk(tw_err == it.e, it.r, "tw_err", int'(tw_err), int'(it.e));
        chk(cyc - it.t == LAT, "R6", "latency", cyc - it.t, LAT);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int st2[12] = '{0,0,0,0,0,0,0,3,0,3,0,3};
    int st3[12] = '{0,0,0,0,2,4,0,1,2,0,3,6};
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9: reset state
    chk(tw_valid == 1'b0, "R9", "tw_valid", int'(tw_valid), 0);
    chk(tw_addr == '0, "R9", "tw_addr", int'(tw_addr), 0);
    chk(tw_err == 1'b0, "R9", "tw_err", int'(tw_err), 0);
    rst = 1'b0;

    // R1: stage 1 sweep, radices C2:2 C1:3 C0:2
    for (int n = 0; n < 12; n++) send(1, n / 6, (n / 2) % 3, n % 2, 0, 1'b0, "R1");
    // R4: stage 2 sweep, same radices
    for (int n = 0; n < 12; n++) send(2, n / 6, (n / 2) % 3, n % 2, st2[n], 1'b0, "R4");
    idle(3);
    // R5: stage 3 sweep, radices C2:2 C1:2 C0:3, with gaps (R6)
    for (int n = 0; n < 12; n++) begin
      send(3, n / 6, (n / 3) % 2, n % 3, st3[n], 1'b0, "R5");
      if (n % 4 == 3) idle(n % 3 + 1);
    end
    // R2: operand index 0
    send(3, 1, 1, 0, 0, 1'b0, "R2");
    send(2, 1, 2, 0, 0, 1'b0, "R2");
    send(3, 1, 3, 0, 0, 1'b0, "R2");
    // R3: general formula
    send_model(2, 1, 2, 1, "R3");
    send_model(3, 1, 1, 2, "R3");
    send_model(2, 1, 0, 3, "R3");   // 9, below N
    send_model(3, 0, 1, 1, "R3");
    // R7: range check at and above N
    send(3, 0, 2, 3, 0, 1'b1, "R7");  // 3 * 4 = 12
    send(3, 1, 2, 3, 0, 1'b1, "R7");  // 3 * 5 = 15
    send(3, 1, 1, 3, 9, 1'b0, "R7");  // 3 * 3 = 9
    // R8: illegal stage
    send(0, 1, 1, 1, 0, 1'b1, "R8");
    send(0, 0, 0, 0, 0, 1'b1, "R8");
    idle(LAT + 4);

    for (int w = 0; w < 20 && q.size() != 0; w++) @(negedge clk);
    chk(q.size() == 0, "R6", "pending results", q.size(), 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule